// File: doc/BRIEF.md
# Paged effective address generator

This block forms the 16-bit memory address for instruction fetches and for memory-reference operand accesses. It owns four 16-bit pointers. Pointer 0 is the program counter. Every address splits into a 4-bit page field (bits 15:12) and a 12-bit offset (bits 11:0). All arithmetic the block performs changes only the offset, so a sum or an increment wraps inside its 4096-byte page and the page field never moves.

A fetch strobe pre-increments the program counter and presents the new value as the address. An access strobe decodes the mode bit and the pointer select into one of four modes: PC-relative, indexed, immediate or auto-indexed. It then produces the operand address. In auto-indexed mode it also presents a one-cycle write-back of the adjusted pointer. A displacement code of 0x80 stands for "use the extension value instead". A load strobe writes a full 16-bit value into a pointer, and this is the only way to change a page field. Each result appears on registered outputs one clock after its strobe.

Top module: `paged_ea_gen`

## Requirements
- R1: After reset all four pointers are 0x0000, and ea_valid_o and wb_valid_o are low.
- R2: A cycle with fetch_i high adds 1 to the offset of pointer 0, keeping its page, so 0x1FFF becomes 0x1000. The next cycle shows ea_valid_o high and ea_o equal to the new pointer 0.
- R3: An access with mode_i=0 and ptr_sel_i=0 (PC-relative) gives ea_o equal to pointer 0's page, with offset (pointer 0 offset + sign-extended displacement) mod 4096. It does not write any pointer back.
- R4: An access with mode_i=0 and ptr_sel_i of 1 to 3 (indexed) gives the same sum using the selected pointer. The pointer is left unchanged and wb_valid_o stays low.
- R5: An access with mode_i=1 and ptr_sel_i=0 (immediate) gives ea_o equal to pointer 0. The displacement is ignored, even 0x80, and wb_valid_o stays low.
- R6: In the PC-relative, indexed and auto-indexed modes, a displacement of 0x80 is replaced by ext_i, which is read as a signed byte.
- R7: An auto-indexed access (mode_i=1, ptr_sel_i 1 to 3) with a negative effective displacement sets ea_o to pointer + displacement, within the page. The same cycle presents that value as the write-back.
- R8: An auto-indexed access with an effective displacement of zero or more sets ea_o to the old pointer. The write-back carries pointer + displacement, within the page, even when the displacement is zero.
- R9: No access or fetch result has a page field different from that of the pointer it was formed from.
- R10: Only one strobe acts per cycle, with priority fetch_i, then access_i, then ld_i. A lower-priority strobe that coincides with a higher one is ignored. ld_i writes ld_val_i into the pointer chosen by ptr_sel_i, and ptr_rd_o shows that value from the next cycle on.
- R11: wb_valid_o is high for exactly the cycle after each auto-indexed access, and wb_sel_o equals that access's ptr_sel_i. In that same cycle the pointer already holds wb_val_o, as ptr_rd_o shows. A cycle with no strobe leaves both valid outputs low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_i | input | 1 | Instruction byte fetch strobe |
| access_i | input | 1 | Operand access strobe |
| ld_i | input | 1 | Pointer load strobe |
| mode_i | input | 1 | Mode bit of the instruction |
| ptr_sel_i | input | 2 | Pointer select, 0 is the program counter |
| disp_i | input | 8 | Signed displacement |
| ext_i | input | 8 | Extension register value |
| ld_val_i | input | 16 | Value for a pointer load |
| ea_o | output | 16 | Fetch or operand address |
| ea_valid_o | output | 1 | ea_o holds a new address this cycle |
| wb_valid_o | output | 1 | One-cycle write-back strobe |
| wb_sel_o | output | 2 | Pointer being written back |
| wb_val_o | output | 16 | Written-back pointer value |
| pc_o | output | 16 | Current program counter |
| ptr_rd_o | output | 16 | Pointer chosen by ptr_sel_i |

## Verification
The properties assume that mode_i, ptr_sel_i, disp_i and ext_i are stable and meaningful in any cycle where a strobe is high. They also assume that the auto-indexed checks only matter when ptr_sel_i is nonzero. The stimulus drives every field for a full cycle with each strobe and returns all strobes to zero between operations. It also overlaps strobes deliberately to test the priority rule. Idle cycles hold ptr_sel_i on the pointer of interest, so that write-backs and ignored loads can be observed on ptr_rd_o.

// File: rtl/pea_pkg.sv
package pea_pkg;
  localparam int ADDR_W = 16;
  localparam int OFF_W  = 12;
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int DISP_W = 8;
  localparam int NPTR   = 4;
  localparam int SEL_W  = $clog2(NPTR);
  localparam logic [DISP_W-1:0] SUBST_CODE = {1'b1, {(DISP_W-1){1'b0}}};

  typedef enum logic [1:0] {
    AM_PCREL = 2'd0,
    AM_INDEX = 2'd1,
    AM_IMMED = 2'd2,
    AM_AUTO  = 2'd3
  } amode_e;

  typedef logic [ADDR_W-1:0] addr_t;

  function automatic amode_e decode_mode(input logic m, input logic [SEL_W-1:0] sel);
    if (!m) return (sel == '0) ? AM_PCREL : AM_INDEX;
    return (sel == '0) ? AM_IMMED : AM_AUTO;
  endfunction

  function automatic logic [OFF_W-1:0] sext_disp(input logic [DISP_W-1:0] d);
    return {{(OFF_W-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  function automatic addr_t page_add(input addr_t base, input logic [DISP_W-1:0] d);
    logic [OFF_W-1:0] off;
    off = base[OFF_W-1:0] + sext_disp(d);
    return {base[ADDR_W-1:OFF_W], off};
  endfunction

  function automatic addr_t page_inc(input addr_t base);
    logic [OFF_W-1:0] off;
    off = base[OFF_W-1:0] + {{(OFF_W-1){1'b0}}, 1'b1};
    return {base[ADDR_W-1:OFF_W], off};
  endfunction
endpackage

// File: rtl/pea_ptr_file.sv
module pea_ptr_file
  import pea_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pc_inc,
  input  logic                         wb_en,
  input  logic [SEL_W-1:0]             wb_sel,
  input  addr_t                        wb_val,
  input  logic                         ld_en,
  input  logic [SEL_W-1:0]             ld_sel,
  input  addr_t                        ld_val,
  output logic [NPTR-1:0][ADDR_W-1:0]  ptrs
);
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
    addr_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if ((g == 0) && pc_inc) begin
        q <= page_inc(q);
      end else if (wb_en && (wb_sel == IDX)) begin
        q <= wb_val;
      end else if (ld_en && (ld_sel == IDX)) begin
        q <= ld_val;
      end
    end
    assign ptrs[g] = q;
  end
endmodule

// File: rtl/pea_addr_calc.sv
module pea_addr_calc
  import pea_pkg::*;
(
  input  logic                         mode_i,
  input  logic [SEL_W-1:0]             sel_i,
  input  logic [DISP_W-1:0]            disp_i,
  input  logic [DISP_W-1:0]            ext_i,
  input  logic [NPTR-1:0][ADDR_W-1:0]  ptrs_i,
  output addr_t                        ea_o,
  output addr_t                        base_o,
  output logic [DISP_W-1:0]            eff_disp_o,
  output logic                         wb_need_o,
  output addr_t                        wb_val_o
);
  amode_e mode;
  logic   subst;
  addr_t  moved;

  always_comb begin
    mode       = decode_mode(mode_i, sel_i);
    base_o     = ptrs_i[sel_i];
    subst      = (mode != AM_IMMED) && (disp_i == SUBST_CODE);
    eff_disp_o = subst ? ext_i : disp_i;
    moved      = page_add(base_o, eff_disp_o);
    wb_need_o  = 1'b0;
    wb_val_o   = moved;
    unique case (mode)
      AM_PCREL, AM_INDEX: ea_o = moved;
      AM_IMMED:           ea_o = base_o;
      AM_AUTO: begin
        ea_o      = eff_disp_o[DISP_W-1] ? moved : base_o;
        wb_need_o = 1'b1;
      end
      default:            ea_o = base_o;
    endcase
  end
endmodule

// File: rtl/pea_out_reg.sv
module pea_out_reg
  import pea_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_take,
  input  addr_t            fetch_addr,
  input  logic             acc_take,
  input  addr_t            acc_addr,
  input  logic             wb_en,
  input  logic [SEL_W-1:0] wb_sel_in,
  input  addr_t            wb_val_in,
  output addr_t            ea_o,
  output logic             ea_valid_o,
  output logic             wb_valid_o,
  output logic [SEL_W-1:0] wb_sel_o,
  output addr_t            wb_val_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_o       <= '0;
      ea_valid_o <= 1'b0;
      wb_valid_o <= 1'b0;
      wb_sel_o   <= '0;
      wb_val_o   <= '0;
    end else begin
      ea_valid_o <= fetch_take || acc_take;
      wb_valid_o <= wb_en;
      if (fetch_take)    ea_o <= fetch_addr;
      else if (acc_take) ea_o <= acc_addr;
      if (wb_en) begin
        wb_sel_o <= wb_sel_in;
        wb_val_o <= wb_val_in;
      end
    end
  end
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen
  import pea_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_i,
  input  logic                 access_i,
  input  logic                 ld_i,
  input  logic                 mode_i,
  input  logic [SEL_W-1:0]     ptr_sel_i,
  input  logic [DISP_W-1:0]    disp_i,
  input  logic [DISP_W-1:0]    ext_i,
  input  logic [ADDR_W-1:0]    ld_val_i,
  output logic [ADDR_W-1:0]    ea_o,
  output logic                 ea_valid_o,
  output logic                 wb_valid_o,
  output logic [SEL_W-1:0]     wb_sel_o,
  output logic [ADDR_W-1:0]    wb_val_o,
  output logic [ADDR_W-1:0]    pc_o,
  output logic [ADDR_W-1:0]    ptr_rd_o
);
  logic [NPTR-1:0][ADDR_W-1:0] ptrs;
  logic              fetch_take, acc_take, ld_take;
  addr_t             calc_ea, calc_base, calc_wb_val, fetch_addr;
  logic [DISP_W-1:0] eff_disp;
  logic              wb_need, wb_en;

  assign fetch_take = fetch_i;
  assign acc_take   = access_i && !fetch_i;
  assign ld_take    = ld_i && !fetch_i && !access_i;
  assign wb_en      = acc_take && wb_need;
  assign fetch_addr = page_inc(ptrs[0]);

  pea_ptr_file u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .pc_inc (fetch_take),
    .wb_en  (wb_en),
    .wb_sel (ptr_sel_i),
    .wb_val (calc_wb_val),
    .ld_en  (ld_take),
    .ld_sel (ptr_sel_i),
    .ld_val (ld_val_i),
    .ptrs   (ptrs)
  );

  pea_addr_calc u_calc (
    .mode_i     (mode_i),
    .sel_i      (ptr_sel_i),
    .disp_i     (disp_i),
    .ext_i      (ext_i),
    .ptrs_i     (ptrs),
    .ea_o       (calc_ea),
    .base_o     (calc_base),
    .eff_disp_o (eff_disp),
    .wb_need_o  (wb_need),
    .wb_val_o   (calc_wb_val)
  );

  pea_out_reg u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_take (fetch_take),
    .fetch_addr (fetch_addr),
    .acc_take   (acc_take),
    .acc_addr   (calc_ea),
    .wb_en      (wb_en),
    .wb_sel_in  (ptr_sel_i),
    .wb_val_in  (calc_wb_val),
    .ea_o       (ea_o),
    .ea_valid_o (ea_valid_o),
    .wb_valid_o (wb_valid_o),
    .wb_sel_o   (wb_sel_o),
    .wb_val_o   (wb_val_o)
  );

  assign pc_o     = ptrs[0];
  assign ptr_rd_o = ptrs[ptr_sel_i];
endmodule

// File: rtl/pea_checker.sv
module pea_checker
  import pea_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_i,
  input logic              access_i,
  input logic              mode_i,
  input logic [SEL_W-1:0]  ptr_sel_i,
  input addr_t             ea_o,
  input logic              ea_valid_o,
  input logic              wb_valid_o,
  input logic [SEL_W-1:0]  wb_sel_o,
  input addr_t             wb_val_o,
  input addr_t             pc_o,
  input addr_t             ptr_rd_o,
  input logic              acc_take,
  input addr_t             calc_base,
  input logic [DISP_W-1:0] eff_disp
);
  logic auto_acc;
  assign auto_acc = acc_take && mode_i && (ptr_sel_i != '0);

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_i |=> ea_valid_o && (ea_o == pc_o)
      && (pc_o[ADDR_W-1:OFF_W] == $past(pc_o[ADDR_W-1:OFF_W]))
      && (pc_o[OFF_W-1:0] == $past(pc_o[OFF_W-1:0]) + 12'd1));

  p_page_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_take |=> ea_valid_o && (ea_o[ADDR_W-1:OFF_W] == $past(calc_base[ADDR_W-1:OFF_W])));

  p_index_no_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_take && !mode_i) |=> !wb_valid_o);

  p_immed_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_take && mode_i && (ptr_sel_i == '0)) |=> (ea_o == pc_o) && !wb_valid_o);

  p_auto_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_acc && eff_disp[DISP_W-1]) |=> wb_valid_o && (ea_o == wb_val_o));

  p_auto_post_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_acc && !eff_disp[DISP_W-1]) |=> wb_valid_o && (ea_o == $past(calc_base)));

  p_wb_origin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> $past(auto_acc) && (wb_sel_o == $past(ptr_sel_i)));

  p_wb_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid_o && (ptr_sel_i == wb_sel_o)) |-> (ptr_rd_o == wb_val_o));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_i && !access_i) |=> !ea_valid_o && !wb_valid_o);
endmodule

bind paged_ea_gen pea_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_i    (fetch_i),
  .access_i   (access_i),
  .mode_i     (mode_i),
  .ptr_sel_i  (ptr_sel_i),
  .ea_o       (ea_o),
  .ea_valid_o (ea_valid_o),
  .wb_valid_o (wb_valid_o),
  .wb_sel_o   (wb_sel_o),
  .wb_val_o   (wb_val_o),
  .pc_o       (pc_o),
  .ptr_rd_o   (ptr_rd_o),
  .acc_take   (acc_take),
  .calc_base  (calc_base),
  .eff_disp   (eff_disp)
);

// File: tb/tb_paged_ea_gen.sv
`timescale 1ns/1ps
module tb_paged_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_i = 0, access_i = 0, ld_i = 0, mode_i = 0;
  logic [1:0]  ptr_sel_i = 0;
  logic [7:0]  disp_i = 0, ext_i = 0;
  logic [15:0] ld_val_i = 0;
  logic [15:0] ea_o, wb_val_o, pc_o, ptr_rd_o;
  logic        ea_valid_o, wb_valid_o;
  logic [1:0]  wb_sel_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #2 clk = ~clk;

  paged_ea_gen dut (.*);

  // behavioural reference
  int p [4];
  int exp_ea = 0, exp_wbval = 0, exp_wbsel = 0;
  bit exp_v = 0, exp_wbv = 0;

  function automatic int wrap_add(int base, int d);
    int off;
    off = ((base % 4096) + d + 4096) % 4096;
    return (base / 4096) * 4096 + off;
  endfunction

  task automatic chk(string tag, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (p[i]) p[i] = 0;
      exp_v = 0; exp_wbv = 0;
    end else begin
      exp_v = 0; exp_wbv = 0;
      if (fetch_i) begin
        p[0] = wrap_add(p[0], 1);
        exp_ea = p[0]; exp_v = 1;
      end else if (access_i) begin
        int base, d, sd, moved;
        base = p[ptr_sel_i];
        exp_v = 1;
        if (mode_i && ptr_sel_i == 0) begin
          exp_ea = base;
        end else begin
          d = (disp_i == 8'd128) ? int'(ext_i) : int'(disp_i);
          sd = (d >= 128) ? d - 256 : d;
          moved = wrap_add(base, sd);
          if (!mode_i) exp_ea = moved;
          else begin
            exp_ea = (sd < 0) ? moved : base;
            exp_wbv = 1; exp_wbsel = ptr_sel_i; exp_wbval = moved;
            p[ptr_sel_i] = moved;
          end
        end
      end else if (ld_i) begin
        p[ptr_sel_i] = int'(ld_val_i);
      end
    end
    #1;
    if (rst_n && !finished) begin
      chk(cur_req, int'(ea_valid_o), int'(exp_v), "ea_valid_o");
      if (exp_v) chk(cur_req, int'(ea_o), exp_ea, "ea_o");
      chk(cur_req, int'(wb_valid_o), int'(exp_wbv), "wb_valid_o");
      if (exp_wbv) begin
        chk(cur_req, int'(wb_sel_o), exp_wbsel, "wb_sel_o");
        chk(cur_req, int'(wb_val_o), exp_wbval, "wb_val_o");
      end
      chk(cur_req, int'(pc_o), p[0], "pc_o");
      chk(cur_req, int'(ptr_rd_o), p[ptr_sel_i], "ptr_rd_o");
    end
  end

  task automatic op(string tag, bit f, bit a, bit l, bit m, int sel,
                    int disp, int ext, int ldv);
    @(negedge clk);
    cur_req = tag;
    fetch_i = f; access_i = a; ld_i = l; mode_i = m;
    ptr_sel_i = 2'(sel); disp_i = 8'(disp); ext_i = 8'(ext); ld_val_i = 16'(ldv);
    @(posedge clk); #1.5;
  endtask

  task automatic idle(string tag, int sel);
    op(tag, 0, 0, 0, 0, sel, 0, 0, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #0.5;
    chk("R1", int'(ea_valid_o), 0, "ea_valid_o after reset");
    chk("R1", int'(wb_valid_o), 0, "wb_valid_o after reset");
    chk("R1", int'(pc_o), 0, "pc_o after reset");
    chk("R1", int'(ptr_rd_o), 0, "ptr_rd_o after reset");

    op("R2", 1, 0, 0, 0, 0, 0, 0, 0);    chk("R2", int'(ea_o), 'h0001, "first fetch");
    op("R2", 1, 0, 0, 0, 0, 0, 0, 0);    chk("R2", int'(ea_o), 'h0002, "second fetch");
    op("R10", 0, 0, 1, 0, 0, 0, 0, 'h1FFF);
    op("R2", 1, 0, 0, 0, 0, 0, 0, 0);    chk("R2", int'(ea_o), 'h1000, "fetch wrap in page");

    op("R10", 0, 0, 1, 0, 0, 0, 0, 'h2FFE);
    op("R3", 0, 1, 0, 0, 0, 'h10, 0, 0); chk("R9", int'(ea_o), 'h200E, "pc-rel wrap forward");
    op("R3", 0, 1, 0, 0, 0, 'hFD, 0, 0); chk("R3", int'(ea_o), 'h2FFB, "pc-rel negative");

    op("R10", 0, 0, 1, 0, 1, 0, 0, 'h4080);
    op("R4", 0, 1, 0, 0, 1, 'h7F, 0, 0); chk("R4", int'(ea_o), 'h40FF, "indexed +127");
    idle("R4", 1);                       chk("R4", int'(ptr_rd_o), 'h4080, "indexed keeps pointer");
    op("R6", 0, 1, 0, 0, 1, 'h80, 'h05, 0); chk("R6", int'(ea_o), 'h4085, "ext substitution +5");
    op("R6", 0, 1, 0, 0, 1, 'h80, 'h90, 0); chk("R6", int'(ea_o), 'h4010, "ext substitution -112");

    op("R5", 0, 1, 0, 1, 0, 'h80, 'h33, 0);
    chk("R5", int'(ea_o), 'h2FFE, "immediate uses pc");
    chk("R5", int'(wb_valid_o), 0, "immediate no write-back");

    op("R10", 0, 0, 1, 0, 2, 0, 0, 'h5000);
    op("R7", 0, 1, 0, 1, 2, 'hFE, 0, 0);
    chk("R7", int'(ea_o), 'h5FFE, "auto pre-decrement address");
    chk("R7", int'(wb_val_o), 'h5FFE, "auto pre-decrement write-back");
    chk("R11", int'(ptr_rd_o), 'h5FFE, "pointer committed with strobe");

    op("R10", 0, 0, 1, 0, 3, 0, 0, 'h6100);
    op("R8", 0, 1, 0, 1, 3, 'h03, 0, 0);
    chk("R8", int'(ea_o), 'h6100, "auto post-increment address");
    chk("R8", int'(wb_val_o), 'h6103, "auto post-increment write-back");
    op("R11", 0, 1, 0, 1, 3, 'h03, 0, 0);
    chk("R11", int'(ea_o), 'h6103, "back-to-back auto uses committed value");
    chk("R11", int'(wb_val_o), 'h6106, "back-to-back write-back");
    op("R6", 0, 1, 0, 1, 3, 'h80, 'hF0, 0);
    chk("R6", int'(ea_o), 'h60F6, "auto with ext substitution");
    op("R8", 0, 1, 0, 1, 3, 'h00, 0, 0);
    chk("R8", int'(ea_o), 'h60F6, "auto zero displacement address");
    chk("R8", int'(wb_valid_o), 1, "auto zero displacement strobe");

    op("R10", 1, 1, 0, 0, 0, 'h10, 0, 0);
    chk("R10", int'(ea_o), 'h2FFF, "fetch beats access");
    op("R10", 0, 1, 1, 0, 1, 'h01, 0, 'hAAAA);
    idle("R10", 1);
    chk("R10", int'(ptr_rd_o), 'h4080, "load ignored under access");
    chk("R11", int'(ea_valid_o), 0, "idle cycle no address");

    op("R10", 0, 0, 1, 0, 1, 0, 0, 'hBEEF);
    idle("R10", 1);
    chk("R10", int'(ptr_rd_o), 'hBEEF, "load visible");

    repeat (3) idle("R11", 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule